// File: doc/BRIEF.md
# Grayscale OLED power-up command sequencer

This block brings up a 16-level grayscale dot-matrix OLED controller by streaming a fixed set of configuration commands as soon as reset is released. Each command is an opcode byte followed by zero, one or two argument bytes. Every byte is offered on an 8-bit valid/ready output together with a command/data flag. Opcode and argument bytes both go out on the command channel.

Most argument values are constants. Three of them are derived from the panel geometry, which is set through the parameters `PANEL_W` and `PANEL_H`:

- The column end address is half the width minus one, because each column byte packs two 4-bit pixels.
- The row end address is the height minus one.
- The multiplex ratio is the height minus one.

When the last byte has been taken, a one-cycle done pulse is raised. The block then stays silent until the next reset. A downstream serial or I2C transmitter consumes the stream.

Top module: `oled_init_seq`

## Requirements
- R1: After reset is released, `valid_o` is high, `byte_o` is 0x81 and `done_o` is low, before any handshake.
- R2: Exactly 32 bytes are emitted, in this order: 81 80, 15 00 CE, 75 00 RE, A0 53, A1 00, A2 00, A4, A8 RE, B1 55, B9, B3 01, AB 01, B6 01, BC 08, BE 07, D5 62 (hex). CE and RE are defined in R3.
- R3: CE = (PANEL_W/2 − 1) and RE = (PANEL_H − 1). Both are taken modulo 256, so only the low 8 bits are kept.
- R4: `dc_o` is 0 for every byte offered, including argument bytes.
- R5: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `byte_o` does not change on the next cycle.
- R6: `done_o` is high for exactly one cycle, the cycle after the edge where the 32nd byte is accepted.
- R7: After the done pulse, `valid_o` and `done_o` stay low until reset, whatever `ready_i` does.
- R8: A reset in the middle of the sequence restarts it from the first byte (0x81).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Downstream accepts the offered byte |
| valid_o | output | 1 | A byte is offered |
| byte_o | output | 8 | Offered opcode or argument byte |
| dc_o | output | 1 | Command/data flag, 0 = command channel |
| done_o | output | 1 | One-cycle pulse when the sequence is complete |

## Verification
A byte is accepted on the rising edge where `valid_o` and `ready_i` are both high. The next byte is visible right after that edge, and `done_o` rises on the edge that accepts the 32nd byte. The bench changes `ready_i` 2 ns after a rising edge and samples on the falling edge. Each falling edge therefore sees the byte that the coming edge will accept. The done pulse is expected one falling edge after the last accepted byte, and silence is expected on every falling edge after that. Stall stability is checked by comparing the byte of a refused cycle with the byte on the next falling edge.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;
  localparam int SEQ_LEN = 32;
  localparam int IDX_W   = $clog2(SEQ_LEN);
  typedef logic [7:0] byte_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef enum logic {ST_RUN = 1'b0, ST_IDLE = 1'b1} seq_state_e;
endpackage

// File: rtl/oled_seq_rom.sv
module oled_seq_rom
  import oled_seq_pkg::*;
#(
  parameter int PANEL_W = 128,
  parameter int PANEL_H = 128
) (
  input  idx_t  idx_i,
  output byte_t byte_o
);
  localparam byte_t COL_END = 8'((PANEL_W / 2) - 1);
  localparam byte_t ROW_END = 8'(PANEL_H - 1);

  always_comb begin
    unique case (idx_i)
      5'd0:  byte_o = 8'h81;  // contrast
      5'd1:  byte_o = 8'h80;
      5'd2:  byte_o = 8'h15;  // column window
      5'd3:  byte_o = 8'h00;
      5'd4:  byte_o = COL_END;
      5'd5:  byte_o = 8'h75;  // row window
      5'd6:  byte_o = 8'h00;
      5'd7:  byte_o = ROW_END;
      5'd8:  byte_o = 8'hA0;  // remap
      5'd9:  byte_o = 8'h53;
      5'd10: byte_o = 8'hA1;  // start line
      5'd11: byte_o = 8'h00;
      5'd12: byte_o = 8'hA2;  // offset
      5'd13: byte_o = 8'h00;
      5'd14: byte_o = 8'hA4;  // normal mode
      5'd15: byte_o = 8'hA8;  // mux ratio
      5'd16: byte_o = ROW_END;
      5'd17: byte_o = 8'hB1;  // phase length
      5'd18: byte_o = 8'h55;
      5'd19: byte_o = 8'hB9;  // linear gray table
      5'd20: byte_o = 8'hB3;  // clock
      5'd21: byte_o = 8'h01;
      5'd22: byte_o = 8'hAB;  // internal regulator
      5'd23: byte_o = 8'h01;
      5'd24: byte_o = 8'hB6;  // precharge period
      5'd25: byte_o = 8'h01;
      5'd26: byte_o = 8'hBC;  // precharge level
      5'd27: byte_o = 8'h08;
      5'd28: byte_o = 8'hBE;  // vcomh
      5'd29: byte_o = 8'h07;
      5'd30: byte_o = 8'hD5;  // function B
      5'd31: byte_o = 8'h62;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/oled_seq_ctrl.sv
module oled_seq_ctrl
  import oled_seq_pkg::*;
#(
  parameter int LEN = SEQ_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  output idx_t idx_o,
  output logic valid_o,
  output logic done_o
);
  localparam idx_t LAST = idx_t'(LEN - 1);

  seq_state_e state_q;
  idx_t       idx_q;
  logic       done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_RUN && ready_i) begin
        if (idx_q == LAST) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + idx_t'(1);
        end
      end
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = (state_q == ST_RUN);
  assign done_o  = done_q;
endmodule

// File: rtl/oled_init_seq.sv
module oled_init_seq
  import oled_seq_pkg::*;
#(
  parameter int PANEL_W = 128,
  parameter int PANEL_H = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] byte_o,
  output logic       dc_o,
  output logic       done_o
);
  localparam logic CMD_CHANNEL = 1'b0;

  idx_t idx;

  oled_seq_ctrl #(.LEN(SEQ_LEN)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (ready_i),
    .idx_o   (idx),
    .valid_o (valid_o),
    .done_o  (done_o)
  );

  oled_seq_rom #(.PANEL_W(PANEL_W), .PANEL_H(PANEL_H)) i_rom (
    .idx_i  (idx),
    .byte_o (byte_o)
  );

  // args travel on the command channel too
  assign dc_o = CMD_CHANNEL;
endmodule

// File: rtl/oled_init_seq_chk.sv
module oled_init_seq_chk
  import oled_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_i,
  input logic       valid_o,
  input logic [7:0] byte_o,
  input logic       done_o
);
  logic [6:0] acc_cnt;
  logic       finished;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt  <= '0;
      finished <= 1'b0;
    end else begin
      if (valid_o && ready_i && acc_cnt != 7'h7F) acc_cnt <= acc_cnt + 7'd1;
      if (done_o) finished <= 1'b1;
    end
  end

  AST_FIRST_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && acc_cnt == 7'd0) |-> byte_o == 8'h81);  // R1
  AST_DONE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> acc_cnt == 7'(SEQ_LEN));  // R2
  AST_NO_EXTRA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cnt >= 7'(SEQ_LEN)) |-> !valid_o);  // R2
  AST_HOLD_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(byte_o)));  // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R6
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && acc_cnt == 7'(SEQ_LEN - 1)) |=> done_o);  // R6
  AST_IDLE_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finished |-> (!valid_o && !done_o));  // R7
endmodule

bind oled_init_seq oled_init_seq_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_i (ready_i),
  .valid_o (valid_o),
  .byte_o  (byte_o),
  .done_o  (done_o)
);

// File: tb/test_oled_init_seq.sv
`timescale 1ns/1ps
module test_oled_init_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready_a = 1'b0, ready_b = 1'b0;
  logic valid_a, valid_b, dc_a, dc_b, done_a, done_b;
  logic [7:0] byte_a, byte_b;

  int n_tests = 0, n_fail = 0;
  bit sel = 1'b0, mon_en = 1'b0, finished = 1'b0;
  int post_cnt = 0;
  bit prev_stall = 1'b0;
  logic [7:0] prev_byte;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  oled_init_seq i_oled_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .ready_i(ready_a),
    .valid_o(valid_a), .byte_o(byte_a), .dc_o(dc_a), .done_o(done_a));

  oled_init_seq #(.PANEL_W(600), .PANEL_H(260)) i_oled_init_seq_wide (
    .clk_i(clk), .rst_ni(rst_n), .ready_i(ready_b),
    .valid_o(valid_b), .byte_o(byte_b), .dc_o(dc_b), .done_o(done_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // driver side: expected stream from R2/R3
  task automatic push_seq(input int w, input int h);
    logic [7:0] ce, re;
    ce = 8'(w / 2 - 1);
    re = 8'(h - 1);
    exp_q.delete();
    exp_q = '{8'h81, 8'h80, 8'h15, 8'h00, ce, 8'h75, 8'h00, re,
              8'hA0, 8'h53, 8'hA1, 8'h00, 8'hA2, 8'h00, 8'hA4, 8'hA8, re,
              8'hB1, 8'h55, 8'hB9, 8'hB3, 8'h01, 8'hAB, 8'h01,
              8'hB6, 8'h01, 8'hBC, 8'h08, 8'hBE, 8'h07, 8'hD5, 8'h62};
    post_cnt = 0;
    prev_stall = 1'b0;
  endtask

  // monitor: samples on falling edge
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      logic v, r, d, c;
      logic [7:0] b;
      v = sel ? valid_b : valid_a;
      r = sel ? ready_b : ready_a;
      d = sel ? done_b : done_a;
      c = sel ? dc_b : dc_a;
      b = sel ? byte_b : byte_a;
      if (post_cnt == 1) begin
        chk(d && !v, "R6 done pulse after last accept", {d, v}, 2'b10);
        post_cnt = 2;
      end else if (post_cnt >= 2) begin
        chk(!d && !v, "R7 silent after done", {d, v}, 2'b00);
        post_cnt++;
      end else begin
        if (prev_stall)
          chk(v && b == prev_byte, "R5 byte held during stall", b, prev_byte);
        chk(!d, "R6 no early done", d, 0);
        prev_stall = 1'b0;
        if (v && r) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 extra byte", b, 0);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(b == e, "R2/R3 byte stream", b, e);
            chk(c == 1'b0, "R4 dc low", c, 0);
            if (exp_q.size() == 0) post_cnt = 1;
          end
        end else if (v) begin
          prev_stall = 1'b1;
          prev_byte = b;
        end
      end
    end
  end

  task automatic drive_full(input bit s);
    int k = 0;
    while (post_cnt < 2) begin
      @(posedge clk); #2;
      if (s) ready_b = ((k * 7) % 5) > 1; else ready_a = ((k * 3) % 4) != 0;
      k++;
    end
    repeat (8) begin  // R7: ready high after completion
      @(posedge clk); #2;
      if (s) ready_b = 1'b1; else ready_a = 1'b1;
    end
    @(posedge clk); #2;
    ready_a = 1'b0; ready_b = 1'b0;
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(valid_a && byte_a == 8'h81 && !done_a, "R1 reset state a", byte_a, 8'h81);
    chk(valid_b && byte_b == 8'h81 && !done_b, "R1 reset state b", byte_b, 8'h81);
    chk(!dc_a && !dc_b, "R4 dc low at reset", {dc_a, dc_b}, 0);

    // default geometry: CE=3F RE=7F
    sel = 1'b0; push_seq(128, 128); mon_en = 1'b1;
    drive_full(1'b0);

    // wide instance stalled throughout: still on first byte (R5)
    @(negedge clk);
    chk(valid_b && byte_b == 8'h81, "R5 long stall holds first byte", byte_b, 8'h81);

    // 600x260: CE=2B, RE=03 after truncation (R3)
    sel = 1'b1; push_seq(600, 260); mon_en = 1'b1;
    drive_full(1'b1);

    // R8: reset mid-sequence
    sel = 1'b0;
    @(posedge clk); #2 rst_n = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    push_seq(128, 128); mon_en = 1'b1;
    while (exp_q.size() > 26) begin
      @(posedge clk); #2 ready_a = 1'b1;
    end
    @(posedge clk); #2;
    ready_a = 1'b0; mon_en = 1'b0; rst_n = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk(valid_a && byte_a == 8'h81 && !done_a, "R8 restart from first byte", byte_a, 8'h81);
    push_seq(128, 128); mon_en = 1'b1;
    drive_full(1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule